// File: doc/BRIEF.md
# DMA Window Address Translator

This block sits between a DMA-capable bus master and system memory. It turns a 32-bit bus address into a 34-bit memory address by checking four programmable windows. Each window has a base register, a size mask and a target base. The lowest-numbered enabled window whose base matches the address does the translation. An address that no enabled window claims passes through unchanged.

A window maps in one of two ways. In direct mode the upper address bits come from the target base and the lower bits from the bus address. In scatter-gather mode the block reads one 64-bit page table entry over its memory read port. It then joins the page frame from that entry to the 8 KiB page offset of the bus address.

Only one translation is in flight at a time. Requests use a valid/ready handshake, and each result is delivered with a one-cycle valid strobe.

Top module: `dwx_translator`

## Requirements
- R1: When several enabled windows match, the window with the lowest index supplies the result.
- R2: A window matches when the bus address equals the window base on every bit in 31:20 where the window mask is 0. Mask bits that are 1 exclude that bit from the compare.
- R3: Bit 0 of a window base enables the window. A matching window with bit 0 clear has no effect on the result.
- R4: Direct mode (base bit 1 = 0) forms the result as follows. Bits 19:0, and each bit in 31:20 where the mask is 1, come from the bus address. All other bits of the 34-bit result come from the target base.
- R5: With no enabled matching window, the result is the bus address zero-extended to 34 bits.
- R6: Scatter-gather mode (base bit 1 = 1) issues one memory read. Its address is built in two parts. The first is the target base with bits 9:0 cleared, and also the mask's 31:20 bits shifted right by 10 cleared. The second is the bus address bits selected by mask bits 31:20 and by bits 19:13, shifted right by 10. The read address is the OR of the two.
- R7: The scatter-gather result is entry bits 21:1 in result bits 33:13, with bus address bits 12:0 in result bits 12:0. This is the result truncated to 34 bits.
- R8: A direct or pass-through translation raises `rsp_valid` for exactly one cycle. It does so on the clock edge that accepts the request.
- R9: `req_ready` is low from the acceptance of a scatter-gather request until the edge on which the entry data is taken.
- R10: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen high, and then `mem_req_valid` drops.
- R11: Synchronous reset leaves `rsp_valid` and `mem_req_valid` low and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| win_base | input | 128 | Window bases, window i in bits [32i+31:32i]; bit 0 enable, bit 1 scatter-gather |
| win_mask | input | 128 | Window size masks, window i in bits [32i+31:32i] |
| win_xbase | input | 136 | Target bases, window i in bits [34i+33:34i] |
| rsp_valid | output | 1 | One-cycle strobe: result valid |
| rsp_addr | output | 34 | Translated address |
| mem_req_valid | output | 1 | Page table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 34 | Page table entry address |
| mem_rsp_valid | input | 1 | Page table entry data valid |
| mem_rsp_data | input | 64 | Page table entry |

## Verification
The assertions assume the window registers stay constant while a translation is in flight. They also assume memory returns entry data only after it has accepted the read request. The stimulus respects both. Window values change only between translations, when the block is idle. `mem_rsp_valid` is driven only after the request handshake has finished, and only for one cycle.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  // lowest bit of the window compare field
  localparam int MATCH_LO = 20;
  // lowest bit of the page number (8 KiB pages)
  localparam int PAGE_LO  = 13;
  // right shift from page number to entry index
  localparam int IDX_SH   = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } dwx_state_e;
endpackage

// File: rtl/dwx_window.sv
module dwx_window
  import dwx_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int SYS_W = 34
) (
  input  logic [BUS_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] base,
  input  logic [BUS_W-1:0] mask,
  input  logic [SYS_W-1:0] xbase,
  output logic             hit,
  output logic             sg,
  output logic [SYS_W-1:0] direct_addr,
  output logic [SYS_W-1:0] pte_addr
);
  localparam int EXT_W = SYS_W - BUS_W;
  localparam logic [BUS_W-1:0] CMP_M  = {{(BUS_W-MATCH_LO){1'b1}}, {MATCH_LO{1'b0}}};
  localparam logic [BUS_W-1:0] LOW_M  = {{(BUS_W-MATCH_LO){1'b0}}, {MATCH_LO{1'b1}}};
  localparam logic [BUS_W-1:0] PAGE_M = {{(BUS_W-MATCH_LO){1'b0}},
                                         {(MATCH_LO-PAGE_LO){1'b1}}, {PAGE_LO{1'b0}}};
  localparam logic [SYS_W-1:0] IDX_LOW = {{(SYS_W-IDX_SH){1'b0}}, {IDX_SH{1'b1}}};

  logic [BUS_W-1:0] size_m;
  logic [BUS_W-1:0] cmp_m;
  logic [SYS_W-1:0] pass_m;
  logic [SYS_W-1:0] bus_x;
  logic [SYS_W-1:0] keep_m;
  logic [SYS_W-1:0] idx;

  always_comb begin
    size_m      = mask & CMP_M;
    cmp_m       = ~mask & CMP_M;
    hit         = (((bus_addr ^ base) & cmp_m) == '0) && base[0];
    sg          = base[1];
    bus_x       = {{EXT_W{1'b0}}, bus_addr};
    pass_m      = {{EXT_W{1'b0}}, size_m | LOW_M};
    direct_addr = (xbase & ~pass_m) | (bus_x & pass_m);
    keep_m      = ~(({{EXT_W{1'b0}}, size_m} >> IDX_SH) | IDX_LOW);
    idx         = {{EXT_W{1'b0}}, bus_addr & (size_m | PAGE_M)} >> IDX_SH;
    pte_addr    = (xbase & keep_m) | idx;
  end
endmodule

// File: rtl/dwx_prio.sv
module dwx_prio #(
  parameter int NWIN = 4
) (
  input  logic [NWIN-1:0] hits,
  output logic [NWIN-1:0] grant,
  output logic            any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (hits[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dwx_translator.sv
module dwx_translator
  import dwx_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int BUS_W = 32,
  parameter int SYS_W = 34,
  parameter int PTE_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [BUS_W-1:0]      req_addr,
  input  logic [NWIN*BUS_W-1:0] win_base,
  input  logic [NWIN*BUS_W-1:0] win_mask,
  input  logic [NWIN*SYS_W-1:0] win_xbase,
  output logic                  rsp_valid,
  output logic [SYS_W-1:0]      rsp_addr,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [SYS_W-1:0]      mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [PTE_W-1:0]      mem_rsp_data
);
  localparam int EXT_W = SYS_W - BUS_W;
  localparam int FRM_SH = PAGE_LO - 1;

  logic [NWIN-1:0]  hits;
  logic [NWIN-1:0]  sgs;
  logic [NWIN-1:0]  grant;
  logic             any_hit;
  logic [SYS_W-1:0] dir_a [NWIN];
  logic [SYS_W-1:0] pte_a [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    dwx_window #(.BUS_W(BUS_W), .SYS_W(SYS_W)) i_win (
      .bus_addr    (req_addr),
      .base        (win_base[g*BUS_W +: BUS_W]),
      .mask        (win_mask[g*BUS_W +: BUS_W]),
      .xbase       (win_xbase[g*SYS_W +: SYS_W]),
      .hit         (hits[g]),
      .sg          (sgs[g]),
      .direct_addr (dir_a[g]),
      .pte_addr    (pte_a[g])
    );
  end

  dwx_prio #(.NWIN(NWIN)) i_prio (
    .hits  (hits),
    .grant (grant),
    .any   (any_hit)
  );

  logic             sel_sg;
  logic [SYS_W-1:0] sel_dir;
  logic [SYS_W-1:0] sel_pte;

  always_comb begin
    sel_sg  = 1'b0;
    sel_dir = '0;
    sel_pte = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (grant[i]) begin
        sel_sg  = sgs[i];
        sel_dir = dir_a[i];
        sel_pte = pte_a[i];
      end
    end
  end

  dwx_state_e         state_q;
  logic [PAGE_LO-1:0] off_q;
  logic [PTE_W-1:0]   frame;
  logic [SYS_W-1:0]   sg_res;

  always_comb begin
    frame  = {mem_rsp_data[PTE_W-1:1], 1'b0} << FRM_SH;
    sg_res = frame[SYS_W-1:0] | {{(SYS_W-PAGE_LO){1'b0}}, off_q};
  end

  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      rsp_valid     <= 1'b0;
      rsp_addr      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      off_q         <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (any_hit && sel_sg) begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= sel_pte;
              off_q         <= req_addr[PAGE_LO-1:0];
              state_q       <= ST_REQ;
            end else begin
              rsp_valid <= 1'b1;
              rsp_addr  <= any_hit ? sel_dir : {{EXT_W{1'b0}}, req_addr};
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= sg_res;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dwx_checker.sv
module dwx_checker #(
  parameter int NWIN  = 4,
  parameter int BUS_W = 32,
  parameter int SYS_W = 34
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [BUS_W-1:0]      req_addr,
  input logic [NWIN*BUS_W-1:0] win_base,
  input logic                  rsp_valid,
  input logic [SYS_W-1:0]      rsp_addr,
  input logic                  mem_req_valid,
  input logic                  mem_req_ready,
  input logic [SYS_W-1:0]      mem_req_addr,
  input logic                  mem_rsp_valid
);
  logic none_en;
  logic accept;

  always_comb begin
    none_en = 1'b1;
    for (int i = 0; i < NWIN; i++) begin
      if (win_base[i*BUS_W]) none_en = 1'b0;
    end
    accept = req_valid && req_ready;
  end

  // R5: every window disabled -> address returned as is
  p_pass_r5: assert property (@(posedge clk) disable iff (rst)
    accept && none_en |=> rsp_valid && (rsp_addr == {{(SYS_W-BUS_W){1'b0}}, $past(req_addr)}));

  // R8: each acceptance yields either a result or a fetch on the next cycle
  p_accept_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> (rsp_valid != mem_req_valid));

  // R8: a result only follows an acceptance or returned entry data
  p_source_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(accept) || $past(mem_rsp_valid)));

  // R9: no new request while a fetch is outstanding
  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R10: fetch request held until accepted
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10: fetch request drops after its handshake
  p_drop_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R11: state after a reset cycle
  p_reset_r11: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid && !mem_req_valid && req_ready);
endmodule

bind dwx_translator dwx_checker #(.NWIN(NWIN), .BUS_W(BUS_W), .SYS_W(SYS_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .win_base      (win_base),
  .rsp_valid     (rsp_valid),
  .rsp_addr      (rsp_addr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/test_dwx_translator.sv
module test_dwx_translator;
  localparam int NWIN = 4;
  localparam int BW = 32;
  localparam int SW = 34;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [BW-1:0]    req_addr = '0;
  logic [NWIN*BW-1:0] win_base = '0;
  logic [NWIN*BW-1:0] win_mask = '0;
  logic [NWIN*SW-1:0] win_xbase = '0;
  logic             rsp_valid;
  logic [SW-1:0]    rsp_addr;
  logic             mem_req_valid;
  logic             mem_req_ready = 1'b0;
  logic [SW-1:0]    mem_req_addr;
  logic             mem_rsp_valid = 1'b0;
  logic [63:0]      mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dwx_translator i_dwx_translator (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .win_base(win_base), .win_mask(win_mask),
    .win_xbase(win_xbase), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input int rq, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_win(input int w, input logic [31:0] b, input logic [31:0] m,
                         input logic [33:0] x);
    win_base[w*BW +: BW]  = b;
    win_mask[w*BW +: BW]  = m;
    win_xbase[w*SW +: SW] = x;
  endtask

  // one translation, called and returning at a falling edge
  task automatic xlate(input logic [31:0] bus, input logic sg, input logic [63:0] pte,
                       input logic [33:0] paddr, input logic [33:0] exp, input int rq,
                       input int stall);
    req_valid = 1'b1;
    req_addr  = bus;
    @(negedge clk);
    req_valid = 1'b0;
    if (!sg) begin
      chk(8, {63'd0, rsp_valid}, 64'd1);          // R8 strobe after accept
      chk(rq, {30'd0, rsp_addr}, {30'd0, exp});
      @(negedge clk);
      chk(8, {63'd0, rsp_valid}, 64'd0);          // R8 single cycle
    end else begin
      chk(6, {63'd0, mem_req_valid}, 64'd1);      // R6 fetch issued
      chk(6, {30'd0, mem_req_addr}, {30'd0, paddr});
      chk(9, {63'd0, req_ready}, 64'd0);          // R9 busy
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        chk(10, {63'd0, mem_req_valid}, 64'd1);   // R10 held
        chk(10, {30'd0, mem_req_addr}, {30'd0, paddr});
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(10, {63'd0, mem_req_valid}, 64'd0);     // R10 dropped
      chk(9, {63'd0, req_ready}, 64'd0);          // R9 still busy
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk(7, {63'd0, rsp_valid}, 64'd1);          // R7
      chk(rq, {30'd0, rsp_addr}, {30'd0, exp});
      chk(9, {63'd0, req_ready}, 64'd1);          // R9 ready again
    end
  endtask

  typedef struct packed {
    logic [31:0] bus;
    logic        sg;
    logic [63:0] pte;
    logic [33:0] paddr;
    logic [33:0] res;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{32'h4123_4567, 1'b0, 64'd0, 34'd0, 34'h2_0123_4567, 4'd4},           // R4
    '{32'h4FFF_FFFF, 1'b0, 64'd0, 34'd0, 34'h2_0FFF_FFFF, 4'd1},           // R1 W0 over W3
    '{32'h5012_3456, 1'b0, 64'd0, 34'd0, 34'h3_D012_3456, 4'd1},           // R1 W3
    '{32'hC123_0000, 1'b0, 64'd0, 34'd0, 34'h0_C123_0000, 4'd3},           // R3 disabled
    '{32'h8020_0000, 1'b0, 64'd0, 34'd0, 34'h0_8020_0000, 4'd5},           // R5 miss
    '{32'h8012_3456, 1'b1, 64'h0000_0000_0012_3457, 34'h1_0000_0488,
      34'h1_2345_7456, 4'd7},                                              // R6/R7
    '{32'h801F_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 34'h1_0000_07F8,
      34'h3_FFFF_FFFF, 4'd7},                                              // R7 truncation
    '{32'h7FFF_FFFF, 1'b0, 64'd0, 34'd0, 34'h3_FFFF_FFFF, 4'd2}            // R2 W3 only
  };

  initial begin
    set_win(0, 32'h4000_0001, 32'h0FF0_0000, 34'h2_0ABC_DEF0);
    set_win(1, 32'h8000_0003, 32'h0010_0000, 34'h1_0000_07FF);
    set_win(2, 32'hC000_0000, 32'h0FF0_0000, 34'h3_0000_0000);
    set_win(3, 32'h4000_0001, 32'h3FF0_0000, 34'h3_F000_0000);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(11, {63'd0, rsp_valid}, 64'd0);
    chk(11, {63'd0, mem_req_valid}, 64'd0);
    chk(11, {63'd0, req_ready}, 64'd1);

    for (int v = 0; v < 8; v++)
      xlate(VT[v].bus, VT[v].sg, VT[v].pte, VT[v].paddr, VT[v].res, int'(VT[v].rq), 2);

    // R2: clearing the W1 mask narrows its compare to bits 31:20
    set_win(1, 32'h8000_0003, 32'h0000_0000, 34'h1_0000_07FF);
    xlate(32'h8010_0000, 1'b0, 64'd0, 34'd0, 34'h0_8010_0000, 2, 0);
    // R6: narrower mask keeps target base bit 10
    xlate(32'h8000_2000, 1'b1, 64'h2, 34'h1_0000_0408, 34'h0_0000_2000, 6, 0);

    // R5: all windows disabled
    for (int w = 0; w < NWIN; w++) win_base[w*BW] = 1'b0;
    xlate(32'h4123_4567, 1'b0, 64'd0, 34'd0, 34'h0_4123_4567, 5, 0);

    // R11: reset in the middle of a fetch
    for (int w = 0; w < NWIN; w++) win_base[w*BW] = 1'b1;
    req_valid = 1'b1;
    req_addr  = 32'h8000_2000;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(11, {63'd0, mem_req_valid}, 64'd0);
    chk(11, {63'd0, req_ready}, 64'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule